// File: doc/BRIEF.md
# Hardware Deadline-Driven Task Scheduler

This block relieves a processor of periodic timer-tick work. It holds a table of periodic tasks. Each entry is either sleeping until its next release time, ready to run, running, or unused. A timer advances a tick count at a programmable rate. On every tick, the hardware moves each sleeping task whose release time has arrived into the ready set. It then gives that task a fresh absolute deadline and a new next release time, both equal to the old release time plus the task period, since each task's relative deadline equals its period.

The processor talks to the block through one command port. A configure command sets the tick period and the policy, and starts the timer. An add command installs a task. A run command ends the current job and returns the next task to execute. A preempt command switches to a better ready task when one exists. Between commands the processor only watches a single preempt flag. The flag is raised when the best ready task beats the running one. Under the deadline policy the key is the absolute deadline, and the nearest deadline wins. Under the fixed policy the key is a static priority value, and the lower value wins. When two tasks have equal keys, the lower task ID wins. Task IDs are 8 bits wide, and the value 255 is reserved as the idle ID.

Top module: `edf_sched_top`

## Requirements
- R1: After reset the tick count is 0, the running ID is 255 (idle), the preempt flag is clear and the timer is stopped until the first configure command.
- R2: After a configure command with period P, the tick count rises by exactly one every max(P,1) clock cycles, with the first rise max(P,1) cycles after the configure edge.
- R3: A configure command issued while the timer runs leaves the tick count unchanged, and later ticks use the new period and policy.
- R4: On the tick edge where the count reaches a sleeping task's release time r (r <= count), the task becomes ready with absolute deadline r+period, and its next release time becomes r+period.
- R5: With policy bit 0 (cmd_prio[0]=0 at configure), a run command returns the ready task with the smallest absolute deadline, and ties go to the lowest ID.
- R6: With policy bit 1 (cmd_prio[0]=1 at configure), a run command returns the ready task with the smallest static priority value, and ties go to the lowest ID.
- R7: A run command puts the task that was running back to sleep with its pending release time, so that task is not returned again until that release.
- R8: A preempt command takes effect only when the preempt flag is set. The running task then returns to the ready set with its deadline unchanged, and the best ready task becomes the running task. Otherwise the running ID is unchanged.
- R9: The preempt flag is set exactly when a ready task exists and either no task runs or the best ready key is strictly below the running task's key.
- R10: A run command with no ready task sets the running ID to 255 and leaves the preempt flag clear.

Commands use cmd_op = 0 for configure, 1 for add, 2 for run and 3 for preempt. An add command takes its fields from the ports: cmd_id is the task ID, cmd_time is the first release time, cmd_span is the period and cmd_prio is the static priority. A configure command takes its fields from the ports as well: cmd_time is the tick period in clock cycles, and cmd_prio[0] selects the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Command code: 0 configure, 1 add, 2 run, 3 preempt |
| cmd_id | input | 8 | Task ID for the add command |
| cmd_time | input | TIME_W | Release time (add) or tick period (configure) |
| cmd_span | input | TIME_W | Task period (add) |
| cmd_prio | input | PRIO_W | Static priority (add); bit 0 selects the policy (configure) |
| now | output | TIME_W | Current tick count |
| run_id | output | 8 | ID of the running task, 255 when idle |
| preempt_flag | output | 1 | A better ready task is waiting |

## Verification
The bench builds the block with four task entries, 16-bit times and 8-bit priorities. With only four entries it can sweep every ordering of four distinct priority values, and of four distinct deadlines, through a full drain of the ready set. A separate equal-key case exercises the ID tie rule. A scripted run with a long tick period brings release, re-release, the preempt flag, both preempt outcomes and a policy switch in mid-run within reach at known tick counts. Tick periods 0 through 6 are swept to check the first tick interval and the steady interval, and to confirm that reconfiguring leaves the count alone.

// File: rtl/edf_sched_pkg.sv
package edf_sched_pkg;
  localparam int ID_W = 8;
  localparam logic [ID_W-1:0] IDLE_ID = '1;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_SLEEP = 2'd1,
    ST_READY = 2'd2,
    ST_RUN   = 2'd3
  } slot_st_e;

  typedef enum logic [1:0] {
    OP_CFG     = 2'd0,
    OP_ADD     = 2'd1,
    OP_RUN     = 2'd2,
    OP_PREEMPT = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/edf_tick_timer.sv
module edf_tick_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              running,
  input  logic [TIME_W-1:0] period,
  output logic              tick,
  output logic [TIME_W-1:0] now,
  output logic [TIME_W-1:0] now_nx
);
  logic [TIME_W-1:0] div_q, div_d, now_q, now_d;
  logic              tmr_en;

  always_comb begin
    tick   = running && !restart && ((div_q + TIME_W'(1)) >= period);
    div_d  = div_q;
    now_d  = now_q;
    if (restart) begin
      div_d = '0;
    end else if (running) begin
      if (tick) begin
        div_d = '0;
        now_d = now_q + TIME_W'(1);
      end else begin
        div_d = div_q + TIME_W'(1);
      end
    end
    tmr_en = restart || running;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      now_q <= '0;
    end else if (tmr_en) begin
      div_q <= div_d;
      now_q <= now_d;
    end
  end

  assign now    = now_q;
  assign now_nx = now_d;

  // R2
  now_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (now_q == $past(now_q)) || (now_q == $past(now_q) + TIME_W'(1)));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (now_q == $past(now_q)));
endmodule

// File: rtl/edf_task_slot.sv
module edf_task_slot
  import edf_sched_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TIME_W-1:0] now_nx,
  input  logic              use_prio,
  input  logic              add_en,
  input  logic [TIME_W-1:0] add_rel,
  input  logic [TIME_W-1:0] add_per,
  input  logic [PRIO_W-1:0] add_prio,
  input  logic              to_sleep,
  input  logic              to_ready,
  input  logic              to_run,
  output logic              is_ready,
  output logic [TIME_W-1:0] key
);
  slot_st_e          st_q, st_d;
  logic [TIME_W-1:0] rel_q, rel_d, per_q, per_d, dl_q, dl_d;
  logic [PRIO_W-1:0] prio_q, prio_d;
  logic              due, upd;

  always_comb begin
    due    = tick && (st_q == ST_SLEEP) && (rel_q <= now_nx);
    st_d   = st_q;
    rel_d  = rel_q;
    per_d  = per_q;
    dl_d   = dl_q;
    prio_d = prio_q;
    if (due) begin
      st_d  = ST_READY;
      dl_d  = rel_q + per_q;
      rel_d = rel_q + per_q;
    end
    if (to_sleep) st_d = ST_SLEEP;
    if (to_ready) st_d = ST_READY;
    if (to_run)   st_d = ST_RUN;
    if (add_en) begin
      st_d   = ST_SLEEP;
      rel_d  = add_rel;
      per_d  = add_per;
      dl_d   = add_rel;
      prio_d = add_prio;
    end
    upd = due || to_sleep || to_ready || to_run || add_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_EMPTY;
      rel_q  <= '0;
      per_q  <= '0;
      dl_q   <= '0;
      prio_q <= '0;
    end else if (upd) begin
      st_q   <= st_d;
      rel_q  <= rel_d;
      per_q  <= per_d;
      dl_q   <= dl_d;
      prio_q <= prio_d;
    end
  end

  assign is_ready = (st_q == ST_READY);
  assign key      = use_prio ? TIME_W'(prio_q) : dl_q;

  // R4
  release_dl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_READY) && ($past(st_q) == ST_SLEEP)) |->
      ((dl_q == $past(rel_q) + $past(per_q)) && (rel_q == dl_q)));

  // R7
  sleep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_SLEEP) && ($past(st_q) == ST_RUN)) |-> $stable(rel_q));
endmodule

// File: rtl/edf_best_pick.sv
module edf_best_pick #(
  parameter int N      = 8,
  parameter int TIME_W = 16,
  parameter int ID_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             vld,
  input  logic [N-1:0][TIME_W-1:0] keys,
  output logic                     found,
  output logic [ID_W-1:0]          best_id,
  output logic [TIME_W-1:0]        best_key
);
  always_comb begin
    found    = 1'b0;
    best_id  = '0;
    best_key = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (!found || (keys[i] < best_key))) begin
        found    = 1'b1;
        best_id  = ID_W'(i);
        best_key = keys[i];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R5
    min_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld[g] |-> (found && (best_key <= keys[g])));
  end
endmodule

// File: rtl/edf_sched_top.sv
module edf_sched_top
  import edf_sched_pkg::*;
#(
  parameter int N_TASKS = 8,
  parameter int TIME_W  = 16,
  parameter int PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_id,
  input  logic [TIME_W-1:0] cmd_time,
  input  logic [TIME_W-1:0] cmd_span,
  input  logic [PRIO_W-1:0] cmd_prio,
  output logic [TIME_W-1:0] now,
  output logic [7:0]        run_id,
  output logic              preempt_flag
);
  cmd_op_e                      op;
  logic                         is_cfg, is_add, is_run, is_pre;
  logic [TIME_W-1:0]            per_q;
  logic                         pol_q, started_q;
  logic                         tick;
  logic [TIME_W-1:0]            now_nx;
  logic [N_TASKS-1:0]           rdy_vec;
  logic [N_TASKS-1:0][TIME_W-1:0] key_vec;
  logic                         found;
  logic [ID_W-1:0]              best_id;
  logic [TIME_W-1:0]            best_key, run_key;
  logic [ID_W-1:0]              run_q, run_d;
  logic                         run_valid, run_en, pre_switch, do_switch;

  assign op     = cmd_op_e'(cmd_op);
  assign is_cfg = cmd_valid && (op == OP_CFG);
  assign is_add = cmd_valid && (op == OP_ADD);
  assign is_run = cmd_valid && (op == OP_RUN);
  assign is_pre = cmd_valid && (op == OP_PREEMPT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q     <= '0;
      pol_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (is_cfg) begin
      per_q     <= cmd_time;
      pol_q     <= cmd_prio[0];
      started_q <= 1'b1;
    end
  end

  edf_tick_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(is_cfg), .running(started_q),
    .period(per_q), .tick(tick), .now(now), .now_nx(now_nx)
  );

  for (genvar g = 0; g < N_TASKS; g++) begin : g_slot
    edf_task_slot #(.TIME_W(TIME_W), .PRIO_W(PRIO_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .tick(tick), .now_nx(now_nx), .use_prio(pol_q),
      .add_en(is_add && (cmd_id == ID_W'(g))),
      .add_rel(cmd_time), .add_per(cmd_span), .add_prio(cmd_prio),
      .to_sleep(is_run && run_valid && (run_q == ID_W'(g))),
      .to_ready(pre_switch && run_valid && (run_q == ID_W'(g))),
      .to_run(do_switch && (best_id == ID_W'(g))),
      .is_ready(rdy_vec[g]), .key(key_vec[g])
    );
  end

  edf_best_pick #(.N(N_TASKS), .TIME_W(TIME_W), .ID_W(ID_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .vld(rdy_vec), .keys(key_vec),
    .found(found), .best_id(best_id), .best_key(best_key)
  );

  always_comb begin
    run_valid = (run_q != IDLE_ID);
    run_key   = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      if (run_valid && (run_q == ID_W'(i))) run_key = key_vec[i];
    end
    preempt_flag = found && (!run_valid || (best_key < run_key));
    pre_switch   = is_pre && preempt_flag;
    do_switch    = (is_run && found) || pre_switch;
    run_d        = run_q;
    if (is_run)                                       run_d = found ? best_id : IDLE_ID;
    else if (pre_switch)                              run_d = best_id;
    else if (is_add && run_valid && (cmd_id == run_q)) run_d = IDLE_ID;
    run_en = is_run || pre_switch || is_add;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= IDLE_ID;
    else if (run_en) run_q <= run_d;
  end

  assign run_id = run_q;

  // R9
  settle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_run && !tick) |-> !preempt_flag);

  // R10
  idle_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_run && !found) |-> (run_q == IDLE_ID));
endmodule

// File: tb/edf_sched_top_tb.sv
`timescale 1ns/1ps
module edf_sched_top_tb;
  localparam int NT = 4;
  localparam int TW = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [7:0]    cmd_id;
  logic [TW-1:0] cmd_time, cmd_span;
  logic [PW-1:0] cmd_prio;
  logic [TW-1:0] now;
  logic [7:0]    run_id;
  logic          preempt_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  edf_sched_top #(.N_TASKS(NT), .TIME_W(TW), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_id(cmd_id), .cmd_time(cmd_time), .cmd_span(cmd_span),
    .cmd_prio(cmd_prio), .now(now), .run_id(run_id), .preempt_flag(preempt_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_id = '0;
    cmd_time = '0; cmd_span = '0; cmd_prio = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cmd(input int op, input int id, input int t, input int s, input int p);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_id = 8'(id);
    cmd_time = TW'(t); cmd_span = TW'(s); cmd_prio = PW'(p);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_now(input int v);
    while (int'(now) != v) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 now", int'(now), 0);
    chk("R1 run_id", int'(run_id), 255);
    chk("R1 flag", int'(preempt_flag), 0);
    repeat (3) @(negedge clk);
    chk("R1 timer stopped", int'(now), 0);

    // scripted run, deadline policy, tick period 20
    cmd(1, 0, 2, 10, 3);
    cmd(1, 1, 1, 20, 1);
    cmd(1, 2, 2, 5, 2);
    cmd(1, 3, 9, 8, 0);
    cmd(2, 0, 0, 0, 0);
    chk("R10 run empty id", int'(run_id), 255);
    chk("R10 run empty flag", int'(preempt_flag), 0);
    cmd(0, 0, 20, 0, 0);
    wait_now(1);
    chk("R9 idle with ready flag", int'(preempt_flag), 1);
    wait_now(2);
    cmd(2, 0, 0, 0, 0);
    chk("R5 earliest deadline", int'(run_id), 2);
    chk("R9 flag clear after run", int'(preempt_flag), 0);
    cmd(2, 0, 0, 0, 0);
    chk("R7 R5 next pick", int'(run_id), 0);
    cmd(2, 0, 0, 0, 0);
    chk("R7 third pick", int'(run_id), 1);
    cmd(2, 0, 0, 0, 0);
    chk("R10 drained id", int'(run_id), 255);
    chk("R10 drained flag", int'(preempt_flag), 0);
    wait_now(6);
    chk("R4 not yet released", int'(preempt_flag), 0);
    wait_now(7);
    chk("R4 re-release flag", int'(preempt_flag), 1);
    cmd(3, 0, 0, 0, 0);
    chk("R8 preempt from idle", int'(run_id), 2);
    chk("R9 flag after preempt", int'(preempt_flag), 0);
    wait_now(9);
    chk("R9 later deadline no flag", int'(preempt_flag), 0);
    cmd(3, 0, 0, 0, 0);
    chk("R8 preempt without flag", int'(run_id), 2);
    cmd(0, 0, 20, 0, 1);
    chk("R3 now kept", int'(now), 9);
    chk("R6 R9 fixed policy flag", int'(preempt_flag), 1);
    cmd(3, 0, 0, 0, 0);
    chk("R8 switch to best prio", int'(run_id), 3);
    chk("R9 flag after switch", int'(preempt_flag), 0);
    cmd(0, 0, 20, 0, 0);
    chk("R8 deadline kept on return", int'(preempt_flag), 1);
    cmd(3, 0, 0, 0, 0);
    chk("R8 switch back", int'(run_id), 2);

    // ordering sweep over all distinct key permutations, both policies
    for (int pol = 0; pol < 2; pol++) begin
      for (int code = 0; code < 257; code++) begin
        int d[4];
        bit ok;
        ok = 1'b1;
        for (int i = 0; i < 4; i++) d[i] = (code < 256) ? ((code >> (2*i)) & 3) : 1;
        if (code < 256)
          for (int i = 0; i < 4; i++)
            for (int j = i + 1; j < 4; j++) if (d[i] == d[j]) ok = 1'b0;
        if (!ok) continue;
        do_reset();
        for (int i = 0; i < 4; i++)
          cmd(1, i, 0, (pol == 1) ? 100 : 10 + d[i], (pol == 1) ? d[i] : 7);
        cmd(0, 0, 1, 0, pol);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
          int exp_id;
          exp_id = k;
          if (code < 256)
            for (int i = 0; i < 4; i++) if (d[i] == k) exp_id = i;
          cmd(2, 0, 0, 0, 0);
          if (code == 256)  chk("R6 tie lowest id", int'(run_id), exp_id);
          else if (pol == 1) chk("R6 prio order", int'(run_id), exp_id);
          else               chk("R5 deadline order", int'(run_id), exp_id);
        end
        cmd(2, 0, 0, 0, 0);
        chk("R10 idle after drain", int'(run_id), 255);
      end
    end

    // tick period sweep
    do_reset();
    for (int p = 0; p < 7; p++) begin
      int n0, c, ex;
      n0 = int'(now);
      cmd(0, 0, p, 0, 0);
      chk("R3 now unchanged by configure", int'(now), n0);
      ex = (p == 0) ? 1 : p;
      for (int rep = 0; rep < 2; rep++) begin
        n0 = int'(now);
        c = 0;
        do begin
          @(negedge clk);
          c++;
        end while (int'(now) == n0);
        chk("R2 tick interval", c, ex);
        chk("R2 tick step", int'(now), n0 + 1);
      end
    end

    summary();
  end
endmodule